// File: doc/BRIEF.md
# Half-Integer-Capable Sliding DFT Bin

This block computes one bin of a moving-window discrete Fourier transform on a stream of signed fixed-point samples. The bin is produced recursively: every accepted sample passes through a comb stage, and then through a complex one-pole resonator. The result is an in-phase and a quadrature value that tracks the window's spectral content at the selected frequency. A downstream frequency-tracking loop can use the quadrature value as its error term.

The selected bin may be an integer or a half-integer multiple of the window's fundamental. For integer bins the comb subtracts the sample that leaves the window. For half-integer bins it adds that sample. In both cases one comb zero lands exactly on the resonator pole, which lies between the integer DFT bins in the half-integer case. The resonator coefficients carry a small radius leak, so that fixed-point rounding cannot make the state grow without bound.

Every state change happens on the sample strobe. The output flag reports when a full window of samples has been taken in since reset.

Top module: `sdft_halfbin_bin`

## Requirements
- R1: A synchronous reset clears the sample history, the resonator state and the fill count. After reset, `out_i`, `out_q` and `out_valid` are all zero, and the first N samples see zeros as their departing samples.
- R2: `bin_x2` carries twice the bin index: code 1 selects 0.5, 2 selects 1, 3 selects 1.5, 4 selects 2 and 5 selects 2.5. The resonator coefficient is Wr + jWi, with Wr = round(r·cos(π·bin_x2/N)·2^FB) and Wi = round(r·sin(π·bin_x2/N)·2^FB), both divided by 2^FB, where r = 1 − 2^−LEAK.
- R3: For an even `bin_x2` (integer bin), the comb output is c[n] = x[n] − x[n−N].
- R4: For an odd `bin_x2` (half-integer bin), the comb output is c[n] = x[n] + x[n−N].
- R5: On each accepted sample, the state becomes s[n] = W·s[n−1] + c[n]. Each product is rounded to GF fraction bits. `out_i` is the integer part (floor) of Re s and `out_q` is the floor of Im s. Both are visible right after the clock edge that accepts the sample, and both stay within 2 LSB of the exact recursion.
- R6: When `smp_en` is low, no state changes: `out_i`, `out_q` and `out_valid` hold their values, and the sample input is not taken into the history.
- R7: `out_valid` is low until N samples have been accepted since reset. It rises on the edge that accepts the Nth sample and then stays high until reset.
- R8: Out-of-range codes are clamped. `bin_x2` = 0 behaves as code 1, and codes 6 and 7 behave as code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; the sample on `smp_in` is taken on this edge |
| smp_in | input | DW | Signed input sample |
| bin_x2 | input | 3 | Twice the bin index (static during operation) |
| out_i | output | DW+clog2(N)+3 | In-phase output, integer part of the resonator state |
| out_q | output | DW+clog2(N)+3 | Quadrature output, integer part of the resonator state |
| out_valid | output | 1 | High once a full window has been accepted |

## Verification
The bench builds the block with its defaults: N = 16, DW = 12, FB = 14, GF = 10 and LEAK = 10. A 16-sample window fills in a handful of strobes, so valid timing and reset reuse are checked many times per run. All five bin angles fall on multiples of π/16, well below Nyquist. The 10 fraction bits keep the rounding drift of the leaky resonator under one output LSB, so a tight tolerance against a floating-point model of the recursion can still expose a wrong comb sign, a wrong coefficient or a missed strobe.

// File: rtl/sdft_pkg.sv
package sdft_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // resonator pole radius r = 1 - 2^-leak
  function automatic real pole_radius(input int leak);
    return 1.0 - 1.0 / (2.0 ** leak);
  endfunction

  // rounded fixed-point real part of r*exp(j*pi*k2/n)
  function automatic int twid_re(input int k2, input int n, input int fb, input int leak);
    return int'(pole_radius(leak) * $cos(PI_R * k2 / n) * (2.0 ** fb));
  endfunction

  // rounded fixed-point imaginary part of r*exp(j*pi*k2/n)
  function automatic int twid_im(input int k2, input int n, input int fb, input int leak);
    return int'(pole_radius(leak) * $sin(PI_R * k2 / n) * (2.0 ** fb));
  endfunction

  // clamp a bin code into the supported range 1..5
  function automatic logic [2:0] clamp_code(input logic [2:0] code);
    if (code == 3'd0) return 3'd1;
    if (code > 3'd5)  return 3'd5;
    return code;
  endfunction

  // odd codes are half-integer bins
  function automatic logic code_is_half(input logic [2:0] code);
    return code[0];
  endfunction

endpackage

// File: rtl/sdft_delay_line.sv
module sdft_delay_line #(
  parameter int N  = 16,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  logic signed [DW-1:0] tap [N];

  always_ff @(posedge clk) begin
    if (rst)     tap[0] <= '0;
    else if (en) tap[0] <= din;
  end

  for (genvar g = 1; g < N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)     tap[g] <= '0;
      else if (en) tap[g] <= tap[g-1];
    end
  end

  assign dout = tap[N-1];

endmodule

// File: rtl/sdft_comb.sv
module sdft_comb #(
  parameter int DW = 12
) (
  input  logic                 half,
  input  logic signed [DW-1:0] x_new,
  input  logic signed [DW-1:0] x_old,
  output logic signed [DW:0]   comb_out
);

  logic signed [DW:0] a_ext, b_ext;

  always_comb begin
    a_ext = (DW+1)'(x_new);
    b_ext = (DW+1)'(x_old);
    if (half) comb_out = a_ext + b_ext;
    else      comb_out = a_ext - b_ext;
  end

endmodule

// File: rtl/sdft_resonator.sv
module sdft_resonator #(
  parameter int N    = 16,
  parameter int DW   = 12,
  parameter int FB   = 14,
  parameter int GF   = 10,
  parameter int LEAK = 10,
  parameter int IW   = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2:0]           code,
  input  logic signed [DW:0]   comb_in,
  output logic signed [IW-1:0] int_re,
  output logic signed [IW-1:0] int_im
);

  localparam int CW = FB + 2;
  localparam int SW = IW + GF;
  localparam int PW = SW + CW + 1;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FB - 1);

  logic signed [CW-1:0] cos_tab [8];
  logic signed [CW-1:0] sin_tab [8];

  for (genvar g = 0; g < 8; g++) begin : g_twid
    localparam int KC = (g < 1) ? 1 : ((g > 5) ? 5 : g);
    localparam logic signed [CW-1:0] CV = CW'(sdft_pkg::twid_re(KC, N, FB, LEAK));
    localparam logic signed [CW-1:0] SV = CW'(sdft_pkg::twid_im(KC, N, FB, LEAK));
    assign cos_tab[g] = CV;
    assign sin_tab[g] = SV;
  end

  logic signed [SW-1:0] s_re, s_im, n_re, n_im;
  logic signed [CW-1:0] wr, wi;
  logic signed [PW-1:0] p_re, p_im, q_re, q_im;
  logic signed [SW-1:0] c_ext;

  always_comb begin
    wr    = cos_tab[code];
    wi    = sin_tab[code];
    p_re  = PW'(wr) * PW'(s_re) - PW'(wi) * PW'(s_im);
    p_im  = PW'(wr) * PW'(s_im) + PW'(wi) * PW'(s_re);
    q_re  = (p_re + RND) >>> FB;
    q_im  = (p_im + RND) >>> FB;
    c_ext = SW'(comb_in) <<< GF;
    n_re  = SW'(q_re) + c_ext;
    n_im  = SW'(q_im);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_re <= '0;
      s_im <= '0;
    end else if (en) begin
      s_re <= n_re;
      s_im <= n_im;
    end
  end

  assign int_re = s_re[SW-1:GF];
  assign int_im = s_im[SW-1:GF];

endmodule

// File: rtl/sdft_halfbin_bin.sv
module sdft_halfbin_bin #(
  parameter int N    = 16,
  parameter int DW   = 12,
  parameter int FB   = 14,
  parameter int GF   = 10,
  parameter int LEAK = 10,
  localparam int OW  = DW + $clog2(N) + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic signed [DW-1:0] smp_in,
  input  logic [2:0]           bin_x2,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 out_valid
);

  localparam int FCW = $clog2(N + 1);
  localparam logic [FCW-1:0] FULL = FCW'(N);

  logic [2:0]           code_c;
  logic                 half_sel;
  logic signed [DW-1:0] departing;
  logic signed [DW:0]   comb_val;
  logic [FCW-1:0]       fill_cnt;
  logic                 win_full;

  assign code_c   = sdft_pkg::clamp_code(bin_x2);
  assign half_sel = sdft_pkg::code_is_half(code_c);

  sdft_delay_line #(.N(N), .DW(DW)) u_delay (
    .clk (clk), .rst (rst), .en (smp_en), .din (smp_in), .dout (departing)
  );

  sdft_comb #(.DW(DW)) u_comb (
    .half (half_sel), .x_new (smp_in), .x_old (departing), .comb_out (comb_val)
  );

  sdft_resonator #(
    .N(N), .DW(DW), .FB(FB), .GF(GF), .LEAK(LEAK), .IW(OW)
  ) u_res (
    .clk (clk), .rst (rst), .en (smp_en), .code (code_c),
    .comb_in (comb_val), .int_re (out_i), .int_im (out_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                       fill_cnt <= '0;
    else if (smp_en && !win_full)  fill_cnt <= fill_cnt + 1'b1;
  end

  assign win_full  = (fill_cnt == FULL);
  assign out_valid = win_full;

endmodule

// File: rtl/sdft_halfbin_bin_chk.sv
module sdft_halfbin_bin_chk #(
  parameter int N   = 16,
  parameter int OW  = 19,
  parameter int FCW = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_en,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q,
  input logic                 out_valid,
  input logic [FCW-1:0]       fill_cnt
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_i == '0 && out_q == '0 && !out_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(out_i) && $stable(out_q) && $stable(out_valid))); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid); // R7

  AST_VALID_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(smp_en)); // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= FCW'(N)); // R7

endmodule

bind sdft_halfbin_bin sdft_halfbin_bin_chk #(.N(N), .OW(OW), .FCW(FCW)) u_chk (
  .clk (clk), .rst (rst), .smp_en (smp_en), .out_i (out_i), .out_q (out_q),
  .out_valid (out_valid), .fill_cnt (fill_cnt)
);

// File: tb/sdft_halfbin_bin_bench.sv
module sdft_halfbin_bin_bench;

  localparam int  N    = 16;
  localparam int  DW   = 12;
  localparam int  FB   = 14;
  localparam int  GF   = 10;
  localparam int  LEAK = 10;
  localparam int  OW   = DW + 4 + 3;
  localparam real PI_B = 3.14159265358979323846;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_en = 1'b0;
  logic signed [DW-1:0] smp_in = '0;
  logic [2:0]           bin_x2 = 3'd1;
  logic signed [OW-1:0] out_i, out_q;
  logic                 out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int  hist [N];
  real mr, mi, cr, ci;
  int  accepted;
  bit  m_half;

  always #2.5 clk = ~clk;

  sdft_halfbin_bin u_sdft_halfbin_bin (
    .clk (clk), .rst (rst), .smp_en (smp_en), .smp_in (smp_in),
    .bin_x2 (bin_x2), .out_i (out_i), .out_q (out_q), .out_valid (out_valid)
  );

  function automatic real coef(input int k2, input bit im);
    real r, v;
    r = 1.0 - 1.0 / (2.0 ** LEAK);
    v = im ? r * $sin(PI_B * k2 / N) : r * $cos(PI_B * k2 / N);
    return real'(int'(v * (2.0 ** FB))) / (2.0 ** FB);
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic model_reset(input int k2);
    foreach (hist[i]) hist[i] = 0;
    mr = 0.0; mi = 0.0; accepted = 0;
    cr = coef(k2, 1'b0); ci = coef(k2, 1'b1);
    m_half = k2[0];
  endtask

  task automatic do_reset(input logic [2:0] code, input int model_k2);
    @(negedge clk);
    rst = 1'b1; smp_en = 1'b0; bin_x2 = code;
    @(negedge clk);
    rst = 1'b0;
    model_reset(model_k2);
    @(negedge clk);
    check(out_i == 0 && out_q == 0 && !out_valid, "R1", "reset state",
          real'(out_i), 0.0);
  endtask

  task automatic step(input bit en, input int x, input string req);
    int old, c;
    real nr, ni;
    logic signed [OW-1:0] pi, pq;
    logic pv;
    pi = out_i; pq = out_q; pv = out_valid;
    smp_en = en; smp_in = DW'(x);
    @(posedge clk);
    #1;
    if (en) begin
      old = hist[N-1];
      for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      c  = m_half ? x + old : x - old;
      nr = cr * mr - ci * mi + real'(c);
      ni = cr * mi + ci * mr;
      mr = nr; mi = ni;
      accepted++;
      check(absr(real'(out_i) - $floor(mr)) <= 2.0, req, "out_i", real'(out_i), mr);
      check(absr(real'(out_q) - $floor(mi)) <= 2.0, req, "out_q", real'(out_q), mi);
    end else begin
      check(out_i == pi && out_q == pq && out_valid == pv, "R6", "hold on idle",
            real'(out_i), real'(pi));
    end
    check(out_valid == (accepted >= N), "R7", "valid", real'(out_valid),
          real'(accepted >= N));
    @(negedge clk);
  endtask

  task automatic run_bin(input logic [2:0] code, input int k2, input int steps);
    string req;
    req = k2[0] ? "R4" : "R3";
    do_reset(code, k2);
    // tone at the bin angle, then random samples with random strobes
    for (int n = 0; n < steps; n++) begin
      int x;
      bit en;
      if (n < steps / 2) x = int'(2000.0 * $cos(PI_B * k2 * n / N));
      else               x = int'($urandom_range(4095)) - 2048;
      en = ($urandom_range(3) != 0);
      step(en, x, req);
    end
  endtask

  initial begin
    int seed_use;
    seed_use = $urandom(32'h5D1F);
    // R1 reset state with every bin code, R2 coefficients through R5 recursion
    for (int k = 1; k <= 5; k++) run_bin(3'(k), k, 6 * N);
    // R2/R5 directed extremes: full-scale impulse with both signs, integer and half bins
    for (int k = 2; k <= 3; k++) begin
      do_reset(3'(k), k);
      step(1'b1, 2047, "R5");
      for (int n = 0; n < 2 * N; n++) step(1'b1, 0, k[0] ? "R4" : "R3");
      step(1'b1, -2048, "R5");
      for (int n = 0; n < N + 3; n++) step(1'b1, 0, "R5");
    end
    // R1 mid-stream reset leaves no history behind: half bin sees zero departing samples
    run_bin(3'd3, 3, 2 * N);
    do_reset(3'd3, 3);
    for (int n = 0; n < N + 2; n++) step(1'b1, 1500, "R1");
    // R6 long idle gap with a changing sample input
    for (int n = 0; n < 10; n++) step(1'b0, n * 100, "R6");
    step(1'b1, 7, "R6");
    // R8 clamping of out-of-range codes
    run_bin(3'd7, 5, 3 * N);
    run_bin(3'd6, 5, 3 * N);
    run_bin(3'd0, 1, 3 * N);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule